// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the program counter of a 32-bit single-issue processor and computes the address of the next instruction. On each clock edge where the pipeline is not stalled, the counter takes one of four values. It can step to the next word. It can take a PC-relative branch target, measured from the already-incremented counter. It can take a region-preserving jump target, which keeps the top bits of the current counter. It can take an indirect target supplied from a register.

The decoder drives the branch-equal and branch-not-equal strobes, the jump and jump-register strobes, and a link request. The ALU zero flag tells the block whether the two compared operands matched. The block also presents the address of the following instruction as a link value, with a write strobe that the register file can use to record a return address.

Top module: `next_pc_unit`

## Requirements
- R1: With no control transfer, the next PC is the current PC plus 4, modulo 2^32, so 0xFFFFFFFC steps to 0x00000000.
- R2: A taken branch targets (PC + 4) plus the 16-bit displacement, sign-extended and multiplied by 4. Negative displacements move backward, down to displacement 0x8000.
- R3: The branch-equal strobe is taken only when the zero flag is 1 (operands equal). The branch-not-equal strobe is taken only when the zero flag is 0. An untaken branch falls through to PC + 4.
- R4: A jump targets {PC[31:28], field[25:0], 2'b00}, so the top four bits of the current PC are kept.
- R5: A jump-register request loads the PC with the 32-bit register operand unchanged.
- R6: When several requests are present, jump-register wins, then jump, then a taken branch, then the sequential step.
- R7: A synchronous active-high reset sets the PC to parameter RESET_VEC (default 0) at the next edge, even while stall is high.
- R8: While stall is high, the PC keeps its value across the edge. The next-PC output still shows the computed target.
- R9: The link output always equals PC + 4. The link write strobe is high exactly when the link request is present together with jump or jump-register and stall is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Hold the PC this cycle |
| br_disp | input | 16 | Signed branch displacement in words |
| jmp_field | input | 26 | Word target field of a jump |
| reg_target | input | 32 | Register operand for an indirect jump |
| br_eq | input | 1 | Branch if operands equal |
| br_ne | input | 1 | Branch if operands differ |
| alu_zero | input | 1 | Compare result, 1 when operands equal |
| jump | input | 1 | Region-preserving jump |
| jump_reg | input | 1 | Indirect jump through register |
| link_req | input | 1 | Record return address |
| pc_o | output | 32 | Current PC |
| npc_o | output | 32 | Next PC as computed this cycle |
| link_o | output | 32 | Return address, PC + 4 |
| link_we_o | output | 1 | Link write strobe |

## Verification
The most interesting overlap is a branch request arriving in the same cycle as a jump or jump-register request. A decoder fault can raise both, and the priority order then decides the outcome. The vectors include cycles with jump-register, jump and a taken branch all asserted, and cycles with jump plus a taken not-equal branch. In each case the next-PC output must match the higher-priority target and never the branch target. A stall cycle that coincides with a jump-and-link is also driven. The PC must hold, and the link strobe must stay low, while the next-PC output still shows the jump target.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [1:0] {
    SRC_SEQ = 2'd0,
    SRC_BR  = 2'd1,
    SRC_JMP = 2'd2,
    SRC_JR  = 2'd3
  } npc_src_e;
endpackage

// File: rtl/pc_target_gen.sv
module pc_target_gen #(
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int JW = 26
) (
  input  logic [AW-1:0] pc,
  input  logic [DW-1:0] disp,
  input  logic [JW-1:0] jfield,
  output logic [AW-1:0] seq_tgt,
  output logic [AW-1:0] br_tgt,
  output logic [AW-1:0] jmp_tgt
);
  localparam int RW  = AW - JW - 2;
  localparam int EXT = AW - DW - 2;

  logic [AW-1:0] disp_bytes;

  always_comb begin
    seq_tgt    = pc + AW'(4);
    disp_bytes = {{EXT{disp[DW-1]}}, disp, 2'b00};
    br_tgt     = seq_tgt + disp_bytes;
    jmp_tgt    = {pc[AW-1 -: RW], jfield, 2'b00};
  end
endmodule

// File: rtl/pc_branch_eval.sv
module pc_branch_eval (
  input  logic br_eq,
  input  logic br_ne,
  input  logic alu_zero,
  output logic taken
);
  always_comb begin
    taken = (br_eq && alu_zero) || (br_ne && !alu_zero);
  end
endmodule

// File: rtl/pc_select.sv
module pc_select
  import npc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] seq_tgt,
  input  logic [AW-1:0] br_tgt,
  input  logic [AW-1:0] jmp_tgt,
  input  logic [AW-1:0] jr_tgt,
  input  logic          taken,
  input  logic          jump,
  input  logic          jump_reg,
  output logic [AW-1:0] npc,
  output npc_src_e      src
);
  always_comb begin
    if (jump_reg)   src = SRC_JR;
    else if (jump)  src = SRC_JMP;
    else if (taken) src = SRC_BR;
    else            src = SRC_SEQ;
    unique case (src)
      SRC_JR:  npc = jr_tgt;
      SRC_JMP: npc = jmp_tgt;
      SRC_BR:  npc = br_tgt;
      default: npc = seq_tgt;
    endcase
  end
endmodule

// File: rtl/next_pc_unit.sv
module next_pc_unit
  import npc_pkg::*;
#(
  parameter int          AW        = 32,
  parameter int          DW        = 16,
  parameter int          JW        = 26,
  parameter logic [31:0] RESET_VEC = 32'h0000_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stall,
  input  logic [DW-1:0] br_disp,
  input  logic [JW-1:0] jmp_field,
  input  logic [AW-1:0] reg_target,
  input  logic          br_eq,
  input  logic          br_ne,
  input  logic          alu_zero,
  input  logic          jump,
  input  logic          jump_reg,
  input  logic          link_req,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] npc_o,
  output logic [AW-1:0] link_o,
  output logic          link_we_o
);
  localparam int RW = AW - JW - 2;

  logic [AW-1:0] pc_q;
  logic [AW-1:0] seq_tgt, br_tgt, jmp_tgt, npc;
  logic          taken;
  npc_src_e      src;

  pc_target_gen #(.AW(AW), .DW(DW), .JW(JW)) u_tgt (
    .pc(pc_q), .disp(br_disp), .jfield(jmp_field),
    .seq_tgt(seq_tgt), .br_tgt(br_tgt), .jmp_tgt(jmp_tgt)
  );

  pc_branch_eval u_br (
    .br_eq(br_eq), .br_ne(br_ne), .alu_zero(alu_zero), .taken(taken)
  );

  pc_select #(.AW(AW)) u_sel (
    .seq_tgt(seq_tgt), .br_tgt(br_tgt), .jmp_tgt(jmp_tgt), .jr_tgt(reg_target),
    .taken(taken), .jump(jump), .jump_reg(jump_reg), .npc(npc), .src(src)
  );

  always_ff @(posedge clk) begin
    if (rst)         pc_q <= AW'(RESET_VEC);
    else if (!stall) pc_q <= npc;
  end

  assign pc_o      = pc_q;
  assign npc_o     = npc;
  assign link_o    = seq_tgt;
  assign link_we_o = link_req && (jump || jump_reg) && !stall;

  AST_RESET_VEC: assert property (@(posedge clk) rst |=> pc_o == AW'(RESET_VEC)); // R7
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(pc_o)); // R8
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (!stall && !jump && !jump_reg && !br_eq && !br_ne) |=> pc_o == $past(pc_o) + AW'(4)); // R1
  AST_JR_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!stall && jump_reg) |=> pc_o == $past(reg_target)); // R5
  AST_JMP_REGION: assert property (@(posedge clk) disable iff (rst)
    (!stall && jump && !jump_reg) |=> pc_o[AW-1 -: RW] == $past(pc_o[AW-1 -: RW])); // R4
  AST_NO_BR_WHEN_JUMP: assert property (@(posedge clk) disable iff (rst)
    (jump || jump_reg) |-> src != SRC_BR); // R6
  AST_LINK_NEXT: assert property (@(posedge clk) disable iff (rst)
    link_we_o |-> (link_o == pc_o + AW'(4) && !stall)); // R9
endmodule

// File: tb/next_pc_unit_test.sv
module next_pc_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct packed {
    logic [31:0] start;
    logic [15:0] disp;
    logic [25:0] jf;
    logic [31:0] rt;
    logic        beq, bne, zero, jmp, jr, lnk;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{32'h0000_1000, 16'h0000, 26'h0, 32'h0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0}, // R1 step
    '{32'd80012,     16'h0002, 26'h0, 32'h0, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0}, // R2 R3 bne taken -> 80024
    '{32'd80012,     16'h0002, 26'h0, 32'h0, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0}, // R3 bne not taken
    '{32'd80012,     16'hFFFD, 26'h0, 32'h0, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b0}, // R2 R3 beq backward
    '{32'd80012,     16'hFFFD, 26'h0, 32'h0, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0}, // R3 beq not taken
    '{32'd80020,     16'h0000, 26'd20000, 32'h0, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0}, // R4 back to 80000
    '{32'hA000_0010, 16'h0000, 26'h3FF_FFFF, 32'h0, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0}, // R4 region kept
    '{32'h0000_0200, 16'h0000, 26'h0, 32'h1234_5678, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0}, // R5
    '{32'h0000_0300, 16'h0010, 26'h55, 32'hCAFE_0000, 1'b1,1'b0,1'b1,1'b1,1'b1,1'b0}, // R6 jr wins
    '{32'h0000_0300, 16'h0010, 26'h55, 32'hCAFE_0000, 1'b0,1'b1,1'b0,1'b1,1'b0,1'b0}, // R6 jump over branch
    '{32'hFFFF_FFFC, 16'h0000, 26'h0, 32'h0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0}, // R1 wrap
    '{32'h0004_0000, 16'h8000, 26'h0, 32'h0, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b0}, // R2 most negative
    '{32'h0000_0400, 16'h0000, 26'h40, 32'h0, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b1}, // R9 jump and link
    '{32'h0000_0500, 16'h0000, 26'h0, 32'h0000_0800, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b1} // R9 jr and link
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall = 1'b0;
  logic [15:0] br_disp = '0;
  logic [25:0] jmp_field = '0;
  logic [31:0] reg_target = '0;
  logic        br_eq = 1'b0, br_ne = 1'b0, alu_zero = 1'b0;
  logic        jump = 1'b0, jump_reg = 1'b0, link_req = 1'b0;
  logic [31:0] pc_o, npc_o, link_o;
  logic        link_we_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  next_pc_unit uut (
    .clk(clk), .rst(rst), .stall(stall), .br_disp(br_disp), .jmp_field(jmp_field),
    .reg_target(reg_target), .br_eq(br_eq), .br_ne(br_ne), .alu_zero(alu_zero),
    .jump(jump), .jump_reg(jump_reg), .link_req(link_req),
    .pc_o(pc_o), .npc_o(npc_o), .link_o(link_o), .link_we_o(link_we_o)
  );

  function automatic logic [31:0] ref_next(input vec_t v);
    logic [31:0] inc;
    logic        tk;
    inc = v.start + 32'd4;
    tk  = (v.beq && v.zero) || (v.bne && !v.zero);
    if (v.jr)       return v.rt;
    else if (v.jmp) return {v.start[31:28], v.jf, 2'b00};
    else if (tk)    return inc + {{14{v.disp[15]}}, v.disp, 2'b00};
    else            return inc;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    br_eq = 0; br_ne = 0; alu_zero = 0; jump = 0; jump_reg = 0; link_req = 0;
    br_disp = '0; jmp_field = '0; reg_target = '0; stall = 0;
  endtask

  task automatic load_pc(input logic [31:0] a);
    @(negedge clk);
    idle_inputs();
    jump_reg = 1; reg_target = a;
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    check("R7 reset value", pc_o, 32'h0);
    @(negedge clk); rst = 0;

    for (int i = 0; i < NV; i++) begin
      load_pc(VEC[i].start);
      @(negedge clk);
      idle_inputs();
      br_disp = VEC[i].disp; jmp_field = VEC[i].jf; reg_target = VEC[i].rt;
      br_eq = VEC[i].beq; br_ne = VEC[i].bne; alu_zero = VEC[i].zero;
      jump = VEC[i].jmp; jump_reg = VEC[i].jr; link_req = VEC[i].lnk;
      #1;
      check("R1/R2/R3/R4/R5/R6 npc", npc_o, ref_next(VEC[i]));
      check("R9 link value", link_o, VEC[i].start + 32'd4);
      check("R9 link strobe", {31'b0, link_we_o}, {31'b0, VEC[i].lnk && (VEC[i].jmp || VEC[i].jr)});
      @(posedge clk); #1;
      check("R1/R2/R3/R4/R5/R6 pc update", pc_o, ref_next(VEC[i]));
    end

    // R8 stall with jump-and-link: PC holds, npc shows target, no link strobe
    load_pc(32'h0000_0100);
    @(negedge clk);
    idle_inputs();
    stall = 1; jump = 1; link_req = 1; jmp_field = 26'h80;
    #1;
    check("R8 npc under stall", npc_o, 32'h0000_0200);
    check("R9 strobe low under stall", {31'b0, link_we_o}, 32'h0);
    @(posedge clk); #1;
    check("R8 pc held", pc_o, 32'h0000_0100);
    @(negedge clk); stall = 0;
    @(posedge clk); #1;
    check("R8 pc moves after stall", pc_o, 32'h0000_0200);

    // R7 reset wins over stall
    @(negedge clk);
    idle_inputs();
    stall = 1; rst = 1;
    @(posedge clk); #1;
    check("R7 reset under stall", pc_o, 32'h0);
    @(negedge clk); rst = 0; stall = 0;
    @(posedge clk); #1;
    check("R1 step after reset", pc_o, 32'h4);

    finish_run();
  end
endmodule